// File: doc/BRIEF.md
# Quad-Rate Burst-of-Four SRAM Core

This block is a synchronous memory with one shared command and address bus and two separate one-way data ports. One port carries write data in and the other carries read data out. Every access moves a burst of four words. Each data port moves two words per clock cycle. Each cycle presents a low word and a high word side by side, so the whole core runs on a single clock edge. A read burst and a write burst can therefore be in flight at the same time.

Read requests and write requests share command slots under one rule. At most one request is taken per cycle, and a request of a given kind may not follow an accepted request of the same kind in the very next cycle. A request that breaks this rule is dropped and sets a sticky error flag. Writes carry one enable bit per 9-bit byte, so any byte of any word can be left untouched. The array is kept small through a parameter, while the address port keeps its full width.

Top module: `burst4_sram`

## Requirements
- R1: While reset is held and in the first cycle after it, `rd_valid` is 0, `err_flag` is 0 and `rd_lo`/`rd_hi` are all zeros.
- R2: A cycle with `rd_req` and `wr_req` both high is illegal. Neither request is performed: no read data appears, and write-lane data in the next two cycles does not change the array. `err_flag` rises in the following cycle.
- R3: A read request in the cycle right after an accepted read is ignored and sets `err_flag`. The same applies to a write after an accepted write. A rejected request does not count as accepted. A read and a write may alternate in consecutive cycles without error.
- R4: The address selects one burst of four words, numbered 0 to 3. Write words 0 and 1 are taken from `wd_lo` and `wd_hi` in the cycle after the write request. Words 2 and 3 are taken from the same lanes in the cycle after that.
- R5: For a read request in cycle t, `rd_lo`/`rd_hi` show words 0/1 in cycle t+2 and words 2/3 in cycle t+3. `rd_valid` is high in exactly those two cycles unless another read follows.
- R6: Bit b of `wbe_lo`/`wbe_hi` enables byte b, which is bits 9b+8 down to 9b of the word on the matching lane. A clear bit leaves that byte unchanged.
- R7: A read accepted in the cycle after a write to the same burst returns the new data. A write accepted in the cycle after a read does not change that read's data.
- R8: `err_flag` stays high once set until reset, and reset clears it.
- R9: Alternating read and write requests every cycle keep both ports busy. The read data stream is continuous, with `rd_valid` high for back-to-back bursts.
- R10: Only the low `IDX_W` address bits (default 6) select a burst. Addresses that differ only above those bits refer to the same burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_req | input | 1 | Read burst request |
| wr_req | input | 1 | Write burst request |
| addr | input | ADDR_W (17) | Burst address for the request |
| wd_lo | input | BYTE_W*NBYTES (36) | Write data, even word of the current data cycle |
| wd_hi | input | BYTE_W*NBYTES (36) | Write data, odd word of the current data cycle |
| wbe_lo | input | NBYTES (4) | Byte enables for `wd_lo`, 1 = write |
| wbe_hi | input | NBYTES (4) | Byte enables for `wd_hi`, 1 = write |
| rd_lo | output | BYTE_W*NBYTES (36) | Read data, even word |
| rd_hi | output | BYTE_W*NBYTES (36) | Read data, odd word |
| rd_valid | output | 1 | Read data lanes hold a valid word pair |
| err_flag | output | 1 | Sticky flag for a rejected request |

## Verification
Two functions can fall in the same cycle: the array write that ends a burst, and the first fetch of a read burst aimed at the same address. The bench provokes this by issuing a write and then, in the next cycle, a read of the same burst. It expects the freshly written words on the read lanes, byte for byte. A second test reverses the order, issuing a read and then a write the next cycle, and expects the old contents. A full-rate interleave of reads and writes confirms that both ports stay busy with no flag raised.

// File: rtl/b4_pkg.sv
package b4_pkg;

    localparam int ADDR_W_DEF  = 17;
    localparam int BYTE_W_DEF  = 9;
    localparam int NBYTES_DEF  = 4;
    localparam int IDX_W_DEF   = 6;
    localparam int BURST_LEN   = 4;
    localparam int WSEL_W      = $clog2(BURST_LEN);

    typedef enum logic [1:0] {
        RQ_NONE  = 2'd0,
        RQ_READ  = 2'd1,
        RQ_WRITE = 2'd2,
        RQ_BOTH  = 2'd3
    } req_kind_e;

    function automatic req_kind_e req_kind(input logic rd, input logic wr);
        case ({wr, rd})
            2'b01:   return RQ_READ;
            2'b10:   return RQ_WRITE;
            2'b11:   return RQ_BOTH;
            default: return RQ_NONE;
        endcase
    endfunction

endpackage

// File: rtl/b4_cmd_gate.sv
module b4_cmd_gate
    import b4_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rd_req,
    input  logic wr_req,
    output logic rd_go,
    output logic wr_go,
    output logic err
);
    req_kind_e kind;
    logic      rd_last;
    logic      wr_last;
    logic      bad;

    always_comb begin
        kind  = req_kind(rd_req, wr_req);
        rd_go = 1'b0;
        wr_go = 1'b0;
        bad   = 1'b0;
        unique case (kind)
            RQ_READ:  begin rd_go = !rd_last; bad = rd_last; end
            RQ_WRITE: begin wr_go = !wr_last; bad = wr_last; end
            RQ_BOTH:  bad = 1'b1;
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_last <= 1'b0;
            wr_last <= 1'b0;
            err     <= 1'b0;
        end else begin
            rd_last <= rd_go;
            wr_last <= wr_go;
            err     <= err | bad;
        end
    end
endmodule

// File: rtl/b4_wr_path.sv
module b4_wr_path
    import b4_pkg::*;
#(
    parameter  int BYTE_W = BYTE_W_DEF,
    parameter  int NBYTES = NBYTES_DEF,
    parameter  int IDX_W  = IDX_W_DEF,
    localparam int WORD_W = BYTE_W * NBYTES
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   wr_go,
    input  logic [IDX_W-1:0]                       idx,
    input  logic [WORD_W-1:0]                      wd_lo,
    input  logic [WORD_W-1:0]                      wd_hi,
    input  logic [NBYTES-1:0]                      wbe_lo,
    input  logic [NBYTES-1:0]                      wbe_hi,
    output logic                                   cm_en,
    output logic [IDX_W-1:0]                       cm_idx,
    output logic [BURST_LEN-1:0][WORD_W-1:0]       cm_words,
    output logic [BURST_LEN-1:0][NBYTES-1:0]       cm_be
);
    logic              ph1;
    logic              ph2;
    logic [IDX_W-1:0]  idx_q;
    logic [WORD_W-1:0] buf_w0;
    logic [WORD_W-1:0] buf_w1;
    logic [NBYTES-1:0] buf_b0;
    logic [NBYTES-1:0] buf_b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph1 <= 1'b0;
            ph2 <= 1'b0;
        end else begin
            ph1 <= wr_go;
            ph2 <= ph1;
        end
        if (wr_go) idx_q <= idx;
        if (ph1) begin
            buf_w0 <= wd_lo;
            buf_w1 <= wd_hi;
            buf_b0 <= wbe_lo;
            buf_b1 <= wbe_hi;
        end
    end

    // The commit takes the held first pair and the second pair from the live lanes.
    assign cm_en    = ph2;
    assign cm_idx   = idx_q;
    assign cm_words = {wd_hi, wd_lo, buf_w1, buf_w0};
    assign cm_be    = {wbe_hi, wbe_lo, buf_b1, buf_b0};
endmodule

// File: rtl/b4_array.sv
module b4_array
    import b4_pkg::*;
#(
    parameter  int BYTE_W = BYTE_W_DEF,
    parameter  int NBYTES = NBYTES_DEF,
    parameter  int IDX_W  = IDX_W_DEF,
    localparam int WORD_W = BYTE_W * NBYTES
) (
    input  logic                             clk,
    input  logic                             cm_en,
    input  logic [IDX_W-1:0]                 cm_idx,
    input  logic [BURST_LEN-1:0][WORD_W-1:0] cm_words,
    input  logic [BURST_LEN-1:0][NBYTES-1:0] cm_be,
    input  logic [IDX_W-1:0]                 rd_idx,
    input  logic                             rd_half,
    output logic [1:0][WORD_W-1:0]           rd_pair
);
    localparam int DEPTH = (1 << IDX_W) * BURST_LEN;

    logic [WORD_W-1:0] mem [DEPTH];
    logic              hit;

    always_ff @(posedge clk) begin
        if (cm_en) begin
            for (int w = 0; w < BURST_LEN; w++) begin
                for (int b = 0; b < NBYTES; b++) begin
                    if (cm_be[w][b])
                        mem[{cm_idx, WSEL_W'(w)}][b*BYTE_W +: BYTE_W] <= cm_words[w][b*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    // Same-edge commit to the fetched burst is forwarded byte by byte.
    assign hit = cm_en && (cm_idx == rd_idx);

    for (genvar k = 0; k < 2; k++) begin : g_lane
        logic [WSEL_W-1:0] wsel;
        logic [WORD_W-1:0] old;
        assign wsel = {rd_half, 1'(k)};
        assign old  = mem[{rd_idx, wsel}];
        for (genvar b = 0; b < NBYTES; b++) begin : g_byte
            assign rd_pair[k][b*BYTE_W +: BYTE_W] =
                (hit && cm_be[wsel][b]) ? cm_words[wsel][b*BYTE_W +: BYTE_W]
                                        : old[b*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/b4_rd_path.sv
module b4_rd_path
    import b4_pkg::*;
#(
    parameter  int BYTE_W = BYTE_W_DEF,
    parameter  int NBYTES = NBYTES_DEF,
    parameter  int IDX_W  = IDX_W_DEF,
    localparam int WORD_W = BYTE_W * NBYTES
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rd_go,
    input  logic [IDX_W-1:0]       idx,
    output logic [IDX_W-1:0]       fetch_idx,
    output logic                   fetch_half,
    input  logic [1:0][WORD_W-1:0] pair,
    output logic [WORD_W-1:0]      rd_lo,
    output logic [WORD_W-1:0]      rd_hi,
    output logic                   rd_valid
);
    logic ph1;
    logic ph2;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph1      <= 1'b0;
            ph2      <= 1'b0;
            rd_valid <= 1'b0;
            rd_lo    <= '0;
            rd_hi    <= '0;
        end else begin
            ph1      <= rd_go;
            ph2      <= ph1;
            rd_valid <= ph1 | ph2;
            if (ph1 | ph2) begin
                rd_lo <= pair[0];
                rd_hi <= pair[1];
            end
        end
        if (rd_go) fetch_idx <= idx;
    end

    assign fetch_half = ph2;
endmodule

// File: rtl/burst4_sram.sv
module burst4_sram
    import b4_pkg::*;
#(
    parameter  int ADDR_W = ADDR_W_DEF,
    parameter  int BYTE_W = BYTE_W_DEF,
    parameter  int NBYTES = NBYTES_DEF,
    parameter  int IDX_W  = IDX_W_DEF,
    localparam int WORD_W = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wd_lo,
    input  logic [WORD_W-1:0] wd_hi,
    input  logic [NBYTES-1:0] wbe_lo,
    input  logic [NBYTES-1:0] wbe_hi,
    output logic [WORD_W-1:0] rd_lo,
    output logic [WORD_W-1:0] rd_hi,
    output logic              rd_valid,
    output logic              err_flag
);
    logic                             rd_go;
    logic                             wr_go;
    logic [IDX_W-1:0]                 idx;
    logic                             cm_en;
    logic [IDX_W-1:0]                 cm_idx;
    logic [BURST_LEN-1:0][WORD_W-1:0] cm_words;
    logic [BURST_LEN-1:0][NBYTES-1:0] cm_be;
    logic [IDX_W-1:0]                 fetch_idx;
    logic                             fetch_half;
    logic [1:0][WORD_W-1:0]           pair;

    assign idx = addr[IDX_W-1:0];

    b4_cmd_gate u_gate (
        .clk   (clk),
        .rst   (rst),
        .rd_req(rd_req),
        .wr_req(wr_req),
        .rd_go (rd_go),
        .wr_go (wr_go),
        .err   (err_flag)
    );

    b4_wr_path #(.BYTE_W(BYTE_W), .NBYTES(NBYTES), .IDX_W(IDX_W)) u_wr (
        .clk     (clk),
        .rst     (rst),
        .wr_go   (wr_go),
        .idx     (idx),
        .wd_lo   (wd_lo),
        .wd_hi   (wd_hi),
        .wbe_lo  (wbe_lo),
        .wbe_hi  (wbe_hi),
        .cm_en   (cm_en),
        .cm_idx  (cm_idx),
        .cm_words(cm_words),
        .cm_be   (cm_be)
    );

    b4_array #(.BYTE_W(BYTE_W), .NBYTES(NBYTES), .IDX_W(IDX_W)) u_mem (
        .clk     (clk),
        .cm_en   (cm_en),
        .cm_idx  (cm_idx),
        .cm_words(cm_words),
        .cm_be   (cm_be),
        .rd_idx  (fetch_idx),
        .rd_half (fetch_half),
        .rd_pair (pair)
    );

    b4_rd_path #(.BYTE_W(BYTE_W), .NBYTES(NBYTES), .IDX_W(IDX_W)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_go     (rd_go),
        .idx       (idx),
        .fetch_idx (fetch_idx),
        .fetch_half(fetch_half),
        .pair      (pair),
        .rd_lo     (rd_lo),
        .rd_hi     (rd_hi),
        .rd_valid  (rd_valid)
    );
endmodule

// File: rtl/b4_checker.sv
module b4_checker (
    input logic clk,
    input logic rst,
    input logic rd_req,
    input logic wr_req,
    input logic rd_go,
    input logic wr_go,
    input logic rd_valid,
    input logic err_flag
);
    p_both_flags_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_req && wr_req) |=> err_flag);

    p_rd_spacing_r3: assert property (@(posedge clk) disable iff (rst)
        rd_go |=> !rd_go);

    p_wr_spacing_r3: assert property (@(posedge clk) disable iff (rst)
        wr_go |=> !wr_go);

    p_err_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> $past(rd_req || wr_req));

    p_rd_latency_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |-> $past(rd_go, 2));

    p_rd_pair_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |=> rd_valid);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);
endmodule

bind burst4_sram b4_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_req  (rd_req),
    .wr_req  (wr_req),
    .rd_go   (rd_go),
    .wr_go   (wr_go),
    .rd_valid(rd_valid),
    .err_flag(err_flag)
);

// File: tb/sim_burst4_sram.sv
`timescale 1ns/1ps
module sim_burst4_sram;
    localparam int AW = 17;
    localparam int WW = 36;
    localparam int NVEC = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          rd_req, wr_req;
    logic [AW-1:0] addr;
    logic [WW-1:0] wd_lo, wd_hi;
    logic [3:0]    wbe_lo, wbe_hi;
    logic [WW-1:0] rd_lo, rd_hi;
    logic          rd_valid, err_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [WW-1:0] mdl [64][4];

    // {address, seed, per-word byte enables word3..word0}
    localparam logic [64:0] VEC [NVEC] = '{
        {17'h00003, 32'hA5A5_0001, 16'hFFFF},
        {17'h00011, 32'h1234_5678, 16'h0F0F},
        {17'h1FFFF, 32'hDEAD_BEEF, 16'h8421},
        {17'h00020, 32'h0BAD_F00D, 16'h0000},
        {17'h10005, 32'hCAFE_0005, 16'h3C3C},
        {17'h00000, 32'h7777_0000, 16'hF000}
    };

    always #2.5 clk = ~clk;

    burst4_sram u0 (
        .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req), .addr(addr),
        .wd_lo(wd_lo), .wd_hi(wd_hi), .wbe_lo(wbe_lo), .wbe_hi(wbe_hi),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_valid(rd_valid), .err_flag(err_flag)
    );

    function automatic logic [WW-1:0] mkw(input logic [31:0] seed, input int k);
        return {2'(k), 2'b01, seed};
    endfunction

    task automatic check(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic w, input logic [AW-1:0] a,
                        input logic [WW-1:0] lo, input logic [WW-1:0] hi,
                        input logic [3:0] blo, input logic [3:0] bhi);
        rd_req = r; wr_req = w; addr = a;
        wd_lo = lo; wd_hi = hi; wbe_lo = blo; wbe_hi = bhi;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        step(1'b0, 1'b0, '0, '0, '0, 4'h0, 4'h0);
    endtask

    task automatic mdl_put(input logic [AW-1:0] a, input int k, input logic [WW-1:0] d, input logic [3:0] be);
        for (int b = 0; b < 4; b++)
            if (be[b]) mdl[a[5:0]][k][b*9 +: 9] = d[b*9 +: 9];
    endtask

    task automatic wr_burst(input logic [AW-1:0] a, input logic [31:0] seed, input logic [15:0] be);
        step(1'b0, 1'b1, a, '0, '0, 4'h0, 4'h0);
        step(1'b0, 1'b0, '0, mkw(seed, 0), mkw(seed, 1), be[3:0], be[7:4]);
        step(1'b0, 1'b0, '0, mkw(seed, 2), mkw(seed, 3), be[11:8], be[15:12]);
        for (int k = 0; k < 4; k++) mdl_put(a, k, mkw(seed, k), be[k*4 +: 4]);
    endtask

    task automatic rd_check(input logic [AW-1:0] a, input string tag);
        step(1'b1, 1'b0, a, '0, '0, 4'h0, 4'h0);
        idle();
        check({tag, " valid0"}, WW'(rd_valid), WW'(1));
        check({tag, " w0"}, rd_lo, mdl[a[5:0]][0]);
        check({tag, " w1"}, rd_hi, mdl[a[5:0]][1]);
        idle();
        check({tag, " valid1"}, WW'(rd_valid), WW'(1));
        check({tag, " w2"}, rd_lo, mdl[a[5:0]][2]);
        check({tag, " w3"}, rd_hi, mdl[a[5:0]][3]);
        idle();
        check({tag, " valid end"}, WW'(rd_valid), WW'(0));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        rd_req = 0; wr_req = 0; addr = '0; wd_lo = '0; wd_hi = '0; wbe_lo = '0; wbe_hi = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset values
        check("R1 rd_valid", WW'(rd_valid), WW'(0));
        check("R1 err_flag", WW'(err_flag), WW'(0));
        check("R1 rd_lo", rd_lo, '0);
        check("R1 rd_hi", rd_hi, '0);

        // R4/R6: fill, then masked overwrite, then read back (table walk)
        for (int i = 0; i < NVEC; i++)
            wr_burst(VEC[i][64:48], ~VEC[i][47:16], 16'hFFFF);
        for (int i = 0; i < NVEC; i++)
            wr_burst(VEC[i][64:48], VEC[i][47:16], VEC[i][15:0]);
        for (int i = 0; i < NVEC; i++)
            rd_check(VEC[i][64:48], "R4 R6 R5 table");

        // R10: address bits above the index alias
        wr_burst(17'h00040, 32'h4040_4040, 16'hFFFF);
        rd_check(17'h00000, "R10 alias");

        // R7: write then read of the same burst next cycle sees new data
        step(1'b0, 1'b1, 17'h00011, '0, '0, 4'h0, 4'h0);
        step(1'b1, 1'b0, 17'h00011, mkw(32'h0E0E_0E0E, 0), mkw(32'h0E0E_0E0E, 1), 4'hF, 4'h5);
        step(1'b0, 1'b0, '0, mkw(32'h0E0E_0E0E, 2), mkw(32'h0E0E_0E0E, 3), 4'hF, 4'hF);
        mdl_put(17'h00011, 0, mkw(32'h0E0E_0E0E, 0), 4'hF);
        mdl_put(17'h00011, 1, mkw(32'h0E0E_0E0E, 1), 4'h5);
        mdl_put(17'h00011, 2, mkw(32'h0E0E_0E0E, 2), 4'hF);
        mdl_put(17'h00011, 3, mkw(32'h0E0E_0E0E, 3), 4'hF);
        check("R7 fwd valid", WW'(rd_valid), WW'(1));
        check("R7 fwd w0", rd_lo, mdl[17][0]);
        check("R7 fwd w1 masked", rd_hi, mdl[17][1]);
        idle();
        check("R7 fwd w2", rd_lo, mdl[17][2]);
        check("R7 fwd w3", rd_hi, mdl[17][3]);
        idle();

        // R7: read then write next cycle returns the old data
        begin
            logic [WW-1:0] old0, old1, old2, old3;
            old0 = mdl[3][0]; old1 = mdl[3][1]; old2 = mdl[3][2]; old3 = mdl[3][3];
            step(1'b1, 1'b0, 17'h00003, '0, '0, 4'h0, 4'h0);
            step(1'b0, 1'b1, 17'h00003, '0, '0, 4'h0, 4'h0);
            check("R7 old w0", rd_lo, old0);
            check("R7 old w1", rd_hi, old1);
            step(1'b0, 1'b0, '0, mkw(32'h3333_3333, 0), mkw(32'h3333_3333, 1), 4'hF, 4'hF);
            check("R7 old w2", rd_lo, old2);
            check("R7 old w3", rd_hi, old3);
            step(1'b0, 1'b0, '0, mkw(32'h3333_3333, 2), mkw(32'h3333_3333, 3), 4'hF, 4'hF);
            for (int k = 0; k < 4; k++) mdl_put(17'h00003, k, mkw(32'h3333_3333, k), 4'hF);
            idle();
            rd_check(17'h00003, "R7 R4 later write landed");
        end

        // R9: alternating read/write every cycle
        step(1'b0, 1'b1, 17'h0000A, '0, '0, 4'h0, 4'h0);
        step(1'b1, 1'b0, 17'h00020, mkw(32'hAAAA_0000, 0), mkw(32'hAAAA_0000, 1), 4'hF, 4'hF);
        step(1'b0, 1'b1, 17'h0000B, mkw(32'hAAAA_0000, 2), mkw(32'hAAAA_0000, 3), 4'hF, 4'hF);
        for (int k = 0; k < 4; k++) mdl_put(17'h0000A, k, mkw(32'hAAAA_0000, k), 4'hF);
        check("R9 c3 valid", WW'(rd_valid), WW'(1));
        check("R9 c3 w0", rd_lo, mdl[32][0]);
        check("R9 c3 w1", rd_hi, mdl[32][1]);
        step(1'b1, 1'b0, 17'h0000A, mkw(32'hBBBB_0000, 0), mkw(32'hBBBB_0000, 1), 4'hF, 4'hF);
        check("R9 c4 valid", WW'(rd_valid), WW'(1));
        check("R9 c4 w2", rd_lo, mdl[32][2]);
        check("R9 c4 w3", rd_hi, mdl[32][3]);
        step(1'b0, 1'b0, '0, mkw(32'hBBBB_0000, 2), mkw(32'hBBBB_0000, 3), 4'hF, 4'hF);
        for (int k = 0; k < 4; k++) mdl_put(17'h0000B, k, mkw(32'hBBBB_0000, k), 4'hF);
        check("R9 c5 valid", WW'(rd_valid), WW'(1));
        check("R9 c5 w0", rd_lo, mdl[10][0]);
        check("R9 c5 w1", rd_hi, mdl[10][1]);
        idle();
        check("R9 c6 valid", WW'(rd_valid), WW'(1));
        check("R9 c6 w2", rd_lo, mdl[10][2]);
        check("R9 c6 w3", rd_hi, mdl[10][3]);
        idle();
        rd_check(17'h0000B, "R9 second write");
        check("R3 no error on alternation", WW'(err_flag), WW'(0));

        // R3: read right after a read is dropped; a read after the rejected one is taken
        step(1'b1, 1'b0, 17'h00011, '0, '0, 4'h0, 4'h0);
        step(1'b1, 1'b0, 17'h00003, '0, '0, 4'h0, 4'h0);
        check("R3 rd err", WW'(err_flag), WW'(1));
        check("R3 rd first w0", rd_lo, mdl[17][0]);
        step(1'b1, 1'b0, 17'h00020, '0, '0, 4'h0, 4'h0);
        check("R3 rd first w2", rd_lo, mdl[17][2]);
        idle();
        check("R3 third valid", WW'(rd_valid), WW'(1));
        check("R3 third w0", rd_lo, mdl[32][0]);
        check("R3 third w1", rd_hi, mdl[32][1]);
        idle();
        check("R3 third w3", rd_hi, mdl[32][3]);
        idle();
        check("R3 no extra burst", WW'(rd_valid), WW'(0));
        repeat (3) idle();
        check("R8 sticky", WW'(err_flag), WW'(1));
        do_reset();
        check("R8 cleared by reset", WW'(err_flag), WW'(0));

        // R3: write right after a write is dropped
        step(1'b0, 1'b1, 17'h00020, '0, '0, 4'h0, 4'h0);
        step(1'b0, 1'b1, 17'h00003, mkw(32'h5151_5151, 0), mkw(32'h5151_5151, 1), 4'hF, 4'hF);
        check("R3 wr err", WW'(err_flag), WW'(1));
        step(1'b0, 1'b0, '0, mkw(32'h5151_5151, 2), mkw(32'h5151_5151, 3), 4'hF, 4'hF);
        for (int k = 0; k < 4; k++) mdl_put(17'h00020, k, mkw(32'h5151_5151, k), 4'hF);
        idle();
        rd_check(17'h00003, "R3 dropped write kept old");
        rd_check(17'h00020, "R3 accepted write");
        do_reset();

        // R2: both requests in one cycle
        step(1'b1, 1'b1, 17'h00011, '0, '0, 4'h0, 4'h0);
        step(1'b0, 1'b0, '0, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF, 4'hF, 4'hF);
        check("R2 err", WW'(err_flag), WW'(1));
        step(1'b0, 1'b0, '0, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF, 4'hF, 4'hF);
        check("R2 no read c2", WW'(rd_valid), WW'(0));
        idle();
        check("R2 no read c3", WW'(rd_valid), WW'(0));
        rd_check(17'h00011, "R2 no write");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule